// File: doc/BRIEF.md
# Masked Service Request Register

This block collects service requests from a set of channels and presents them to a host. Each channel owns one bit of a 16-bit source register; a one-cycle event pulse from the channel logic sets that bit, and the bit stays set until the host clears or overwrites it. A mask register chooses which source bits may raise a request. A global gate decides whether the masked pending state reaches the external request line.

A separate test output reports the masked pending state whether or not the gate is open. The host can therefore poll for pending work without enabling the line. Bits latched while the gate is closed raise the line as soon as the gate opens. An activity indicator is lit on every addressed host access and stays lit for a set number of clock cycles after the most recent access. Host accesses arrive as simple one-cycle strobes with data; the bus framing around them belongs to another block.

Top module: `svc_req_top`

## Requirements
- R1: After synchronous reset, the source, mask and status words read 0x0000, and the request, test and activity outputs are low.
- R2: A pulse on event input i sets source bit i (0..7) from the next cycle on. With no host access to the source, every source bit keeps its value, and bits 15..8 always read zero.
- R3: A source write loads bits 7..0 of the write data into the source register at the next edge. Write data bits 15..8 are discarded and read back as zero.
- R4: The clear strobe empties the source register, exactly as a write of 0x0000 does. Clear wins over a write in the same cycle.
- R5: An event pulse on bit i in the same cycle as a host clear or write leaves bit i set.
- R6: The test output is high exactly when some source bit is set whose mask bit is also 1, whatever the state of the gate.
- R7: The request line equals the test output while the gate is open and is low while it is closed. Bits latched while the gate was closed raise the line in the cycle after the gate opens.
- R8: Status bit 0 shows the gate and bits 15..1 read zero. The gate-on strobe opens the gate, the gate-off strobe closes it, and gate-off wins when both strobes are present.
- R9: A mask write loads bits 7..0 of the data. Mask bits 15..8 read zero.
- R10: The activity output goes high in the cycle after an access strobe and stays high for exactly STRETCH_CYC cycles after the most recent access. A new access restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 8 | Per-channel event pulses that set source bits |
| src_wr | input | 1 | Source register write strobe |
| src_wdata | input | 16 | Source register write data |
| src_clr | input | 1 | Source register clear strobe |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | Mask register write data |
| gate_on | input | 1 | Open the request gate |
| gate_off | input | 1 | Close the request gate |
| bus_access | input | 1 | One pulse per addressed host cycle |
| src_q | output | 16 | Source register readback |
| mask_q | output | 16 | Mask register readback |
| status_q | output | 16 | Module status word, bit 0 = gate |
| req_o | output | 1 | External service request line |
| test_o | output | 1 | Masked pending state, independent of the gate |
| act_o | output | 1 | Stretched access activity indicator |

## Verification
A wrong source bit appears on the source readback one cycle after the stimulus. Through the mask, it also changes the test output in that same cycle. A gate that sticks or opens on the wrong strobe splits the request line from the test output, and this can be seen whenever a masked bit is pending. A stretch counter that is off by one ends the activity output one cycle early or late, and this is seen only at the end of a full quiet window after the last access. For that reason the bench counts an uninterrupted window as well as a window that a second access restarts.

// File: rtl/svc_req_pkg.sv
package svc_req_pkg;

    localparam int REG_W  = 16;
    localparam int CHAN_N = 8;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_LOAD = 2'd1,
        SRC_ZERO = 2'd2
    } src_op_e;

    typedef struct packed {
        logic opn;
        logic cls;
    } gate_cmd_t;

    // host clear outranks a host write in the same cycle
    function automatic src_op_e pick_src_op(input logic clr, input logic wr);
        if (clr)
            return SRC_ZERO;
        else if (wr)
            return SRC_LOAD;
        return SRC_HOLD;
    endfunction

    // closing outranks opening
    function automatic logic next_gate(input logic cur, input gate_cmd_t cmd);
        if (cmd.cls)
            return 1'b0;
        else if (cmd.opn)
            return 1'b1;
        return cur;
    endfunction

endpackage

// File: rtl/svc_src_reg.sv
module svc_src_reg
    import svc_req_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = CHAN_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_set,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    input  logic         clr,
    output logic [W-1:0] src_q
);

    src_op_e      op;
    logic [N-1:0] bits_q;

    always_comb op = pick_src_op(clr, wr_en);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits_q[i] <= 1'b0;
            else if (evt_set[i])
                bits_q[i] <= 1'b1;
            else begin
                case (op)
                    SRC_ZERO: bits_q[i] <= 1'b0;
                    SRC_LOAD: bits_q[i] <= wr_bits[i];
                    default:  bits_q[i] <= bits_q[i];
                endcase
            end
        end
    end

    if (W > N) begin : g_pad
        assign src_q = {{(W-N){1'b0}}, bits_q};
    end else begin : g_nopad
        assign src_q = bits_q[W-1:0];
    end

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> ((src_q[N-1:0] & $past(evt_set)) == $past(evt_set)));

    assert_clear_empties_R4: assert property (@(posedge clk) disable iff (rst)
        (clr && evt_set == '0) |=> (src_q == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr_en && evt_set == '0) |=> $stable(src_q));

endmodule

// File: rtl/svc_mask_gate.sv
module svc_mask_gate
    import svc_req_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = CHAN_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mask_wr,
    input  logic [N-1:0] mask_bits,
    input  gate_cmd_t    gate_cmd,
    output logic [W-1:0] mask_q,
    output logic         gate_q
);

    logic [N-1:0] m_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q    <= '0;
            gate_q <= 1'b0;
        end else begin
            if (mask_wr)
                m_q <= mask_bits;
            gate_q <= next_gate(gate_q, gate_cmd);
        end
    end

    if (W > N) begin : g_pad
        assign mask_q = {{(W-N){1'b0}}, m_q};
    end else begin : g_nopad
        assign mask_q = m_q[W-1:0];
    end

    assert_off_wins_R8: assert property (@(posedge clk) disable iff (rst)
        gate_cmd.cls |=> !gate_q);

    assert_on_opens_R8: assert property (@(posedge clk) disable iff (rst)
        (gate_cmd.opn && !gate_cmd.cls) |=> gate_q);

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> (mask_q[N-1:0] == $past(mask_bits)));

endmodule

// File: rtl/svc_stretch.sv
module svc_stretch #(
    parameter int STRETCH_CYC = 500000,
    localparam int CNT_W = $clog2(STRETCH_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic access,
    output logic led
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STRETCH_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (access)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign led = (cnt_q != '0);

    assert_access_lights_R10: assert property (@(posedge clk) disable iff (rst)
        access |=> led);

    assert_no_drop_on_access_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(led) |-> !$past(access));

endmodule

// File: rtl/svc_req_top.sv
module svc_req_top
    import svc_req_pkg::*;
#(
    parameter int W           = REG_W,
    parameter int N           = CHAN_N,
    parameter int STRETCH_CYC = 500000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_set,
    input  logic         src_wr,
    input  logic [W-1:0] src_wdata,
    input  logic         src_clr,
    input  logic         mask_wr,
    input  logic [W-1:0] mask_wdata,
    input  logic         gate_on,
    input  logic         gate_off,
    input  logic         bus_access,
    output logic [W-1:0] src_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] status_q,
    output logic         req_o,
    output logic         test_o,
    output logic         act_o
);

    gate_cmd_t cmd;
    logic      gate_q;
    logic      pending;

    assign cmd.opn = gate_on;
    assign cmd.cls = gate_off;

    svc_src_reg #(.W(W), .N(N)) u_src (
        .clk     (clk),
        .rst     (rst),
        .evt_set (evt_set),
        .wr_en   (src_wr),
        .wr_bits (src_wdata[N-1:0]),
        .clr     (src_clr),
        .src_q   (src_q)
    );

    svc_mask_gate #(.W(W), .N(N)) u_mask (
        .clk       (clk),
        .rst       (rst),
        .mask_wr   (mask_wr),
        .mask_bits (mask_wdata[N-1:0]),
        .gate_cmd  (cmd),
        .mask_q    (mask_q),
        .gate_q    (gate_q)
    );

    svc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_act (
        .clk    (clk),
        .rst    (rst),
        .access (bus_access),
        .led    (act_o)
    );

    assign pending  = |(src_q[N-1:0] & mask_q[N-1:0]);
    assign test_o   = pending;
    assign req_o    = pending & gate_q;
    assign status_q = {{(W-1){1'b0}}, gate_q};

    assert_req_gated_R7: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (test_o && status_q[0]));

    assert_open_follows_test_R7: assert property (@(posedge clk) disable iff (rst)
        (status_q[0] && test_o) |-> req_o);

endmodule

// File: tb/svc_req_top_bench.sv
module svc_req_top_bench;

    localparam int W   = 16;
    localparam int N   = 8;
    localparam int STR = 20;

    typedef struct {
        logic [W-1:0] src;
        logic [W-1:0] mask;
        logic [W-1:0] stat;
        logic         req;
        logic         test;
        logic         act;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] evt_set = '0;
    logic         src_wr = 1'b0, src_clr = 1'b0, mask_wr = 1'b0;
    logic [W-1:0] src_wdata = '0, mask_wdata = '0;
    logic         gate_on = 1'b0, gate_off = 1'b0, bus_access = 1'b0;
    logic [W-1:0] src_q, mask_q, status_q;
    logic         req_o, test_o, act_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    exp_t q[$];

    logic [N-1:0] m_src = '0, m_mask = '0;
    logic         m_gate = 1'b0;
    int           m_cnt = 0;

    always #10 clk = ~clk;

    svc_req_top #(.W(W), .N(N), .STRETCH_CYC(STR)) u_svc_req_top (
        .clk(clk), .rst(rst), .evt_set(evt_set), .src_wr(src_wr),
        .src_wdata(src_wdata), .src_clr(src_clr), .mask_wr(mask_wr),
        .mask_wdata(mask_wdata), .gate_on(gate_on), .gate_off(gate_off),
        .bus_access(bus_access), .src_q(src_q), .mask_q(mask_q),
        .status_q(status_q), .req_o(req_o), .test_o(test_o), .act_o(act_o)
    );

    task automatic compare(input exp_t e);
        tests++;
        if (src_q !== e.src || mask_q !== e.mask || status_q !== e.stat ||
            req_o !== e.req || test_o !== e.test || act_o !== e.act) begin
            fails++;
            $display("FAIL %s: got src=%h mask=%h stat=%h req=%b test=%b act=%b exp src=%h mask=%h stat=%h req=%b test=%b act=%b",
                     e.tag, src_q, mask_q, status_q, req_o, test_o, act_o,
                     e.src, e.mask, e.stat, e.req, e.test, e.act);
        end
    endtask

    // monitor: compare one expected item per falling edge
    always @(negedge clk) begin
        if (q.size() > 0)
            compare(q.pop_front());
    end

    task automatic step(input logic [N-1:0] ev, input logic wr, input logic [W-1:0] wd,
                        input logic clr, input logic mwr, input logic [W-1:0] md,
                        input logic on, input logic off, input logic acc, input string tag);
        exp_t e;
        @(negedge clk);
        evt_set = ev; src_wr = wr; src_wdata = wd; src_clr = clr;
        mask_wr = mwr; mask_wdata = md; gate_on = on; gate_off = off; bus_access = acc;
        @(posedge clk);
        #1;
        if (clr)      m_src = '0;
        else if (wr)  m_src = wd[N-1:0];
        m_src = m_src | ev;
        if (mwr) m_mask = md[N-1:0];
        if (off)     m_gate = 1'b0;
        else if (on) m_gate = 1'b1;
        if (acc)            m_cnt = STR;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        e.src  = {{(W-N){1'b0}}, m_src};
        e.mask = {{(W-N){1'b0}}, m_mask};
        e.stat = {{(W-1){1'b0}}, m_gate};
        e.test = |(m_src & m_mask);
        e.req  = e.test & m_gate;
        e.act  = (m_cnt != 0);
        e.tag  = tag;
        q.push_back(e);
        evt_set = '0; src_wr = 0; src_clr = 0; mask_wr = 0;
        gate_on = 0; gate_off = 0; bus_access = 0;
    endtask

    task automatic idle(input string tag);
        step('0, 0, '0, 0, 0, '0, 0, 0, 0, tag);
    endtask

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        @(negedge clk);
        r.src = '0; r.mask = '0; r.stat = '0;
        r.req = 0; r.test = 0; r.act = 0; r.tag = "R1 reset";
        compare(r);
        rst = 1'b0;

        step(8'h04, 0, '0, 0, 0, '0, 0, 0, 0, "R2 event sets bit2");
        idle("R2 hold");
        step('0, 0, '0, 0, 1, 16'hFF04, 0, 0, 0, "R9 mask upper zero / R6 test gate closed");
        step('0, 0, '0, 0, 0, '0, 1, 0, 0, "R7 gate opens latched req / R8");
        step('0, 0, '0, 0, 0, '0, 1, 1, 0, "R8 off wins over on");
        step('0, 1, 16'hAB81, 0, 0, '0, 0, 0, 0, "R3 write discards upper");
        step('0, 0, '0, 0, 1, 16'h0080, 0, 0, 0, "R6 test ignores gate");
        step(8'h01, 0, '0, 1, 0, '0, 0, 0, 0, "R5 event beats clear");
        step(8'h20, 1, 16'h0000, 0, 0, '0, 0, 0, 0, "R5 event beats write");
        step('0, 0, '0, 1, 0, '0, 0, 0, 0, "R4 clear empties");
        step('0, 1, 16'h00FF, 1, 0, '0, 0, 0, 0, "R4 clear wins over write");
        step(8'h80, 0, '0, 0, 0, '0, 0, 0, 0, "R6 pending, gate closed");
        step('0, 0, '0, 0, 0, '0, 1, 0, 0, "R7 later enable raises req");
        step('0, 1, 16'h00FF, 0, 1, 16'h00FF, 0, 0, 0, "R3 full write");
        step('0, 1, 16'h0000, 0, 0, '0, 0, 0, 0, "R4 write zero equals clear");
        step('0, 0, '0, 0, 0, '0, 0, 1, 0, "R8 gate closes");
        step('0, 0, '0, 0, 0, '0, 0, 0, 1, "R10 access lights");
        for (int i = 0; i < STR + 3; i++) idle("R10 stretch window");
        step('0, 0, '0, 0, 0, '0, 0, 0, 1, "R10 access again");
        for (int i = 0; i < 7; i++) idle("R10 partial window");
        step('0, 0, '0, 0, 0, '0, 0, 0, 1, "R10 restart");
        for (int i = 0; i < STR + 3; i++) idle("R10 restarted window");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule